// File: doc/BRIEF.md
# Serial BCD Cathode Display Receiver

This block receives an eight-digit decimal value over a three-wire serial link and drives the cathode-select lines of eight ten-position display tubes. A host moves bits in one at a time with a serial clock. A load-enable line decides when the shifted word reaches a holding latch. A show-enable line blanks or reveals the decoded result. A host that pulses show-enable once per frame therefore changes the visible value at most once per frame. A host that ties show-enable high shows the value all the time.

All four serial inputs are brought into the system clock domain through a synchronizer of `SYNC_STAGES` flops. Edges of the serial clock are found in that domain. The shift chain is built from `STAGES` cascaded `STAGE_W`-bit stages. Each 4-bit field of the latch feeds a BCD decoder that selects exactly one of ten cathodes. The last bit of the chain is presented on a serial-out pin, which changes on the falling serial clock edge, so that further receivers can be chained behind this one.

Top module: `nixie_score_rx`

## Requirements
- R1: After reset the chain and the latch hold zero, so with show_en high each digit lights only its cathode 0 (cathode bits 0, 10, 20 ... 70) and ser_out is 0.
- R2: Each rising edge of ser_clk shifts ser_data into bit 0 of the 32-bit chain and moves every other bit up by one; a word is therefore sent most significant bit first. Digit d is held in chain bits 4d+3..4d.
- R3: While load_en is low, shifting changes neither the latch nor the cathode outputs.
- R4: While load_en is high, the latch follows the chain, so the display tracks every shift. After load_en falls, the latch keeps the last value it took.
- R5: A digit field holding code n from 0 to 9 drives only cathode bit d*10+n of that digit, and this holds with show_en high.
- R6: A digit field holding a code from 10 to 15 drives none of that digit's ten cathodes.
- R7: With show_en low, all 80 cathode outputs are 0. Raising show_en again shows the latch contents unchanged.
- R8: ser_out carries chain bit 31 and is updated only on the falling edge of ser_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_clk | input | 1 | Serial shift clock; data moves in on its rising edge |
| ser_data | input | 1 | Serial data bit |
| load_en | input | 1 | High: latch follows the chain; low: latch holds |
| show_en | input | 1 | High: cathodes driven; low: all cathodes off |
| cathode | output | 80 | Ten one-hot select lines per digit, digit d at bits 10d+9..10d |
| ser_out | output | 1 | Chain bit 31, for cascading further receivers |

## Verification
A corrupted chain bit shows at ser_out within 32 serial clocks, because every chain bit passes through bit 31 on its way out. It shows on the cathodes within one clock of load_en being high. A latch that fails to hold shows up as cathodes that move during shifting with load_en low. A decoder fault lights two cathodes of one digit, lights the wrong one, or lights one for a code of 10 to 15. The bench models the chain bit by bit, so each of these errors is caught within a few system clocks of the serial edge that exposes it.

// File: rtl/nixie_pkg.sv
package nixie_pkg;
  localparam int NX_DIGIT_BITS = 4;
  localparam int NX_CATHODES   = 10;

  // One-hot cathode select for a BCD code; codes above 9 select nothing.
  function automatic logic [NX_CATHODES-1:0] bcd_to_cathode(
    input logic [NX_DIGIT_BITS-1:0] code,
    input logic                     en
  );
    logic [NX_CATHODES-1:0] sel;
    sel = '0;
    for (int n = 0; n < NX_CATHODES; n++) begin
      sel[n] = en && (code == NX_DIGIT_BITS'(n));
    end
    return sel;
  endfunction
endpackage

// File: rtl/nx_input_sync.sv
module nx_input_sync #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] flop [DEPTH];

  genvar i;
  generate
    for (i = 0; i < DEPTH; i++) begin : g_flop
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) flop[0] <= '0;
          else        flop[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) flop[i] <= '0;
          else        flop[i] <= flop[i-1];
        end
      end
    end
  endgenerate

  assign q = flop[DEPTH-1];
endmodule

// File: rtl/nx_shift_chain.sv
module nx_shift_chain #(
  parameter int STAGES  = 4,
  parameter int STAGE_W = 8,
  localparam int CHAIN_W = STAGES * STAGE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk_s,
  input  logic               din_s,
  output logic               sclk_rise,
  output logic               sclk_fall,
  output logic [CHAIN_W-1:0] chain,
  output logic               sout
);
  logic sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_q;
  assign sclk_fall = ~sclk_s & sclk_q;

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [STAGE_W-1:0] q;
      logic               feed;
      if (s == 0) begin : g_head
        assign feed = din_s;
      end else begin : g_tail
        assign feed = g_stage[s-1].q[STAGE_W-1];
      end
      always_ff @(posedge clk) begin
        if (!rst_n)         q <= '0;
        else if (sclk_rise) q <= {q[STAGE_W-2:0], feed};
      end
      assign chain[s*STAGE_W +: STAGE_W] = q;
    end
  endgenerate

  // Cascade output moves on the falling serial edge.
  always_ff @(posedge clk) begin
    if (!rst_n)         sout <= 1'b0;
    else if (sclk_fall) sout <= chain[CHAIN_W-1];
  end
endmodule

// File: rtl/nx_hold_latch.sv
module nx_hold_latch #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] hold
);
  always_ff @(posedge clk) begin
    if (!rst_n)    hold <= '0;
    else if (load) hold <= din;
  end
endmodule

// File: rtl/nx_digit_decode.sv
module nx_digit_decode
  import nixie_pkg::*;
(
  input  logic [NX_DIGIT_BITS-1:0] code,
  input  logic                     en,
  output logic [NX_CATHODES-1:0]   sel
);
  always_comb sel = bcd_to_cathode(code, en);
endmodule

// File: rtl/nixie_score_rx.sv
module nixie_score_rx
  import nixie_pkg::*;
#(
  parameter int STAGES      = 4,
  parameter int STAGE_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_data,
  input  logic load_en,
  input  logic show_en,
  output logic [(STAGES*STAGE_W/NX_DIGIT_BITS)*NX_CATHODES-1:0] cathode,
  output logic ser_out
);
  localparam int CHAIN_W = STAGES * STAGE_W;
  localparam int DIGITS  = CHAIN_W / NX_DIGIT_BITS;

  // Named internal events, brought out for the checker.
  logic [3:0]         sync_q;
  logic               sclk_s, din_s, load_s, show_s;
  logic               sclk_rise, sclk_fall;
  logic [CHAIN_W-1:0] chain;
  logic [CHAIN_W-1:0] hold;

  nx_input_sync #(.WIDTH(4), .DEPTH(SYNC_STAGES)) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({ser_clk, ser_data, load_en, show_en}),
    .q    (sync_q)
  );
  assign {sclk_s, din_s, load_s, show_s} = sync_q;

  nx_shift_chain #(.STAGES(STAGES), .STAGE_W(STAGE_W)) chain_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_s   (sclk_s),
    .din_s    (din_s),
    .sclk_rise(sclk_rise),
    .sclk_fall(sclk_fall),
    .chain    (chain),
    .sout     (ser_out)
  );

  nx_hold_latch #(.WIDTH(CHAIN_W)) latch_i (
    .clk  (clk),
    .rst_n(rst_n),
    .load (load_s),
    .din  (chain),
    .hold (hold)
  );

  genvar d;
  generate
    for (d = 0; d < DIGITS; d++) begin : g_digit
      nx_digit_decode dec_i (
        .code(hold[d*NX_DIGIT_BITS +: NX_DIGIT_BITS]),
        .en  (show_s),
        .sel (cathode[d*NX_CATHODES +: NX_CATHODES])
      );
    end
  endgenerate
endmodule

// File: rtl/nixie_score_rx_chk.sv
module nixie_score_rx_chk #(
  parameter int CHAIN_W = 32,
  parameter int DIGITS  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               sclk_rise,
  input logic               sclk_fall,
  input logic               din_s,
  input logic               load_s,
  input logic               show_s,
  input logic [CHAIN_W-1:0] chain,
  input logic [CHAIN_W-1:0] hold,
  input logic [DIGITS*10-1:0] cathode,
  input logic               ser_out
);
  p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> chain == {$past(chain[CHAIN_W-2:0]), $past(din_s)});

  p_still_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(chain));

  p_hold_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !load_s |=> $stable(hold));

  p_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_s |=> hold == $past(chain));

  p_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !show_s |-> cathode == '0);

  p_sout_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_fall |=> ser_out == $past(chain[CHAIN_W-1]));

  p_sout_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_fall |=> $stable(ser_out));

  genvar d;
  generate
    for (d = 0; d < DIGITS; d++) begin : g_dig
      p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cathode[d*10 +: 10]));
      p_lit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (show_s && hold[d*4 +: 4] < 4'd10) |-> $countones(cathode[d*10 +: 10]) == 1);
      p_bad_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold[d*4 +: 4] > 4'd9 |-> cathode[d*10 +: 10] == '0);
    end
  endgenerate
endmodule

bind nixie_score_rx nixie_score_rx_chk #(.CHAIN_W(CHAIN_W), .DIGITS(DIGITS)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .sclk_rise(sclk_rise),
  .sclk_fall(sclk_fall),
  .din_s    (din_s),
  .load_s   (load_s),
  .show_s   (show_s),
  .chain    (chain),
  .hold     (hold),
  .cathode  (cathode),
  .ser_out  (ser_out)
);

// File: tb/nixie_score_rx_tb_top.sv
module nixie_score_rx_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0, ser_data = 1'b0, load_en = 1'b0, show_en = 1'b0;
  logic [79:0] cathode;
  logic        ser_out;

  int checks = 0;
  int fails  = 0;

  logic [31:0] model_chain = '0;   // bench view of the chain
  logic [31:0] model_shown = '0;   // bench view of the latch

  always #2 clk = ~clk;            // 250 MHz

  nixie_score_rx dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
    .load_en(load_en), .show_en(show_en), .cathode(cathode), .ser_out(ser_out)
  );

  localparam logic [31:0] WORDS [8] = '{
    32'h1234_5678, 32'h9876_5432, 32'h0000_0009, 32'h9999_9999,
    32'hA0B1_C2FF, 32'h5050_5050, 32'hFFFF_FFFF, 32'h0102_0304
  };

  // Expected cathodes: shift a single one to position 10*d + code.
  function automatic logic [79:0] expect_cath(input logic [31:0] w, input bit on);
    logic [79:0] r;
    int          code;
    r = '0;
    if (on) begin
      for (int d = 0; d < 8; d++) begin
        code = int'((w >> (4 * d)) & 32'hF);
        if (code <= 9) r = r | (80'd1 << (10 * d + code));
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // One serial bit: data, rise, fall, each held long enough for the synchronizer.
  task automatic shift_bit(input logic b);
    ser_data = b; idle(4);
    ser_clk  = 1'b1; idle(4);
    ser_clk  = 1'b0; idle(4);
    model_chain = {model_chain[30:0], b};
    if (load_en) model_shown = model_chain;
    check("R8 ser_out", 80'(ser_out), 80'(model_chain[31]));
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) shift_bit(w[i]);
  endtask

  task automatic set_load(input logic v);
    load_en = v; idle(6);
    if (v) model_shown = model_chain;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    show_en = 1'b1;
    idle(6);
    // R1: reset state shows all zeros
    check("R1 reset cathodes", cathode, expect_cath(32'h0, 1'b1));
    check("R1 reset ser_out", 80'(ser_out), 80'(0));

    // Vector walk: shift with load low (display frozen), then load.
    for (int k = 0; k < 8; k++) begin
      send_word(WORDS[k]);
      check("R3 frozen while load low", cathode, expect_cath(model_shown, 1'b1));
      set_load(1'b1);
      set_load(1'b0);
      // R2/R5/R6: latched word decodes per field
      check("R2 R5 R6 decode word", cathode, expect_cath(WORDS[k], 1'b1));
    end

    // R7: blanking and restore
    show_en = 1'b0; idle(6);
    check("R7 blank", cathode, 80'd0);
    show_en = 1'b1; idle(6);
    check("R7 restore", cathode, expect_cath(WORDS[7], 1'b1));

    // R4: transparent while load high, then holds after it falls
    set_load(1'b1);
    shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b0); shift_bit(1'b1);
    check("R4 transparent", cathode, expect_cath(model_chain, 1'b1));
    check("R4 low digit is 9", cathode[9:0], 80'(10'b10_0000_0000));
    set_load(1'b0);
    shift_bit(1'b0); shift_bit(1'b1); shift_bit(1'b1); shift_bit(1'b1);
    check("R4 hold after fall", cathode, expect_cath(model_shown, 1'b1));

    // R6: one bad field among good ones
    send_word(32'h7E65_4321);
    set_load(1'b1); set_load(1'b0);
    check("R6 code 14 dark", cathode[69:60], 80'd0);
    check("R5 digit 7 shows 7", cathode[79:70], 80'(10'b00_1000_0000));

    // R1: reset again clears chain and latch
    rst_n = 1'b0; idle(3); rst_n = 1'b1; idle(6);
    model_chain = '0; model_shown = '0;
    check("R1 re-reset cathodes", cathode, expect_cath(32'h0, 1'b1));
    check("R1 re-reset ser_out", 80'(ser_out), 80'(0));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule